// File: doc/BRIEF.md
# CRTC display timing generator

This block produces the raster timing for one display pipe from a small set of registers that a host writes. Horizontal geometry is counted in 8-pixel characters and vertical geometry in lines. Both totals and both display sizes are written as the count minus one. The block drives horizontal sync, vertical sync, a display-enable strobe and a memory fetch request. It also exposes its running pixel and line counters.

Register writes land in shadow copies. The host writes the geometry registers and then writes a commit word. The whole new set becomes active together at the next frame boundary, so no partial line or frame is produced. From the first geometry write until that boundary, all timing outputs are held quiet. A two-bit power mode selects which of the sync outputs, the display strobe and the fetch request may run. An optional double-scan mode shows every line twice.

Top module: `crtc_timing_gen`

## Requirements
- R1: `pix_x` counts 0 to (T+1)*8-1 and then wraps to 0, where T is the character total in bits [7:0] of address 0. Within a line, `disp_en` can be high only while `pix_x` < (D+1)*8, where D is the character display size in bits [23:16] of address 0.
- R2: `line_y` counts 0 to V and then wraps to 0, where V is the line total in bits [10:0] of address 2. `disp_en` can be high only while `line_y` <= W, where W is bits [26:16] of address 2.
- R3: The horizontal sync is active for `pix_x` in [S, S+8*N). S is the pixel start in bits [10:0] of address 1. N is the 6-bit character width in bits [21:16] of address 1. A width of 0 counts as 1.
- R4: The vertical sync is active for `line_y` in [L, L+M). L is bits [10:0] of address 3. M is the 5-bit line width in bits [20:16] of address 3. A width of 0 counts as 1.
- R5: Bit 31 of address 1 makes `hsync` active low, and bit 31 of address 3 makes `vsync` active low. An inactive sync sits at the value of its polarity bit.
- R6: `pm_mode` 0 (on) lets all outputs run. `pm_mode` 1 (standby) holds `disp_en` low and holds `hsync` inactive, while `vsync` and the fetch request keep running.
- R7: `pm_mode` 2 (suspend) holds `disp_en` low and holds `vsync` inactive, while `hsync` and the fetch request keep running.
- R8: `pm_mode` 3 (off) holds `disp_en` low, holds both syncs inactive, and holds `fetch_req` low.
- R9: In modes 0, 1 and 2, `fetch_req` is high exactly inside the active display region of R1 and R2.
- R10: When bit 0 of the commit word (address 4) is set, each line is scanned twice: `line_y` advances only on every second line wrap, and a frame lasts 2*(V+1) lines.
- R11: A write to addresses 0 to 3 makes all outputs quiet at once: `disp_en` and `fetch_req` go low and both syncs go inactive. A later write to address 4 arms the new set. The set loads at the next frame wrap, which restarts the counters at 0 and releases the outputs in that same cycle. Shadow values have no effect before that wrap.
- R12: If a write to addresses 0 to 3 falls in the same cycle as the armed frame wrap, the set still loads, but the outputs stay quiet until a further commit is applied.
- R13: During and after reset, and until the first commit is applied, the counters start at 0, `disp_en` and `fetch_req` are low, and both syncs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0-3 geometry, 4 commit) |
| wr_data | input | 32 | Register write data |
| pm_mode | input | 2 | Power mode: 0 on, 1 standby, 2 suspend, 3 off |
| hsync | output | 1 | Horizontal sync, polarity per R5 |
| vsync | output | 1 | Vertical sync, polarity per R5 |
| disp_en | output | 1 | Active display strobe |
| fetch_req | output | 1 | Memory fetch request |
| pix_x | output | 11 | Current pixel within the line |
| line_y | output | 11 | Current line within the frame |

## Verification
Two events can land in the same clock edge: the armed frame wrap that loads the shadow set, and a new geometry write that reopens the quiet window. The bench follows the pixel and line counters of the running configuration. It drives a geometry write at exactly the last pixel of the last line, so that the write and the wrap share one edge. It then checks that the counters restart under the new geometry while `disp_en` and `fetch_req` stay low. Only a second commit is allowed to bring the display back. Normal switch-over is judged a different way: the bench tracks the counters with its own model from the first post-commit frame start, and requires quiet outputs in every cycle before that start.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 3;
  localparam int HCHAR_W    = 8;
  localparam int CHAR_SHIFT = 3;
  localparam int PIX_W      = HCHAR_W + CHAR_SHIFT;
  localparam int LINE_W     = 11;
  localparam int HSW_W      = 6;
  localparam int VSW_W      = 5;
  localparam int UPPER_LSB  = 16;
  localparam int SPAN_W     = 16;
  localparam int COMMIT_ADDR = 4;

  typedef enum logic [1:0] {
    PM_ON      = 2'd0,
    PM_STANDBY = 2'd1,
    PM_SUSPEND = 2'd2,
    PM_OFF     = 2'd3
  } pm_mode_t;

  typedef struct packed {
    logic [HCHAR_W-1:0] htot_m1;
    logic [HCHAR_W-1:0] hdisp_m1;
    logic [PIX_W-1:0]   hs_start;
    logic [HSW_W-1:0]   hs_wid;
    logic               hs_low;
    logic [LINE_W-1:0]  vtot_m1;
    logic [LINE_W-1:0]  vdisp_m1;
    logic [LINE_W-1:0]  vs_start;
    logic [VSW_W-1:0]   vs_wid;
    logic               vs_low;
    logic               dbl;
  } crtc_cfg_t;

  // character count minus one -> pixel count
  function automatic logic [PIX_W:0] chars_to_pix(input logic [HCHAR_W-1:0] m1);
    logic [PIX_W:0] n;
    n = (PIX_W+1)'(m1) + (PIX_W+1)'(1);
    return n << CHAR_SHIFT;
  endfunction

  function automatic logic [HSW_W-1:0] eff_hsw(input logic [HSW_W-1:0] w);
    return (w == '0) ? HSW_W'(1) : w;
  endfunction

  function automatic logic [VSW_W-1:0] eff_vsw(input logic [VSW_W-1:0] w);
    return (w == '0) ? VSW_W'(1) : w;
  endfunction

  // pos inside [start, start+len)
  function automatic logic in_span(input logic [SPAN_W-1:0] pos,
                                   input logic [SPAN_W-1:0] start,
                                   input logic [SPAN_W-1:0] len);
    return (pos >= start) && (pos < start + len);
  endfunction
endpackage

// File: rtl/crtc_shadow_regs.sv
module crtc_shadow_regs
  import crtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              frame_wrap,
  output crtc_cfg_t         active,
  output logic              quiet
);
  crtc_cfg_t shadow;
  logic armed;
  logic pending;
  logic timing_wr;
  logic commit_wr;
  logic apply;

  assign timing_wr = wr_en && (wr_addr < ADDR_W'(COMMIT_ADDR));
  assign commit_wr = wr_en && (wr_addr == ADDR_W'(COMMIT_ADDR));
  assign apply     = frame_wrap && armed;
  assign quiet     = pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_W'(0): begin
          shadow.htot_m1  <= wr_data[HCHAR_W-1:0];
          shadow.hdisp_m1 <= wr_data[UPPER_LSB +: HCHAR_W];
        end
        ADDR_W'(1): begin
          shadow.hs_start <= wr_data[PIX_W-1:0];
          shadow.hs_wid   <= wr_data[UPPER_LSB +: HSW_W];
          shadow.hs_low   <= wr_data[DATA_W-1];
        end
        ADDR_W'(2): begin
          shadow.vtot_m1  <= wr_data[LINE_W-1:0];
          shadow.vdisp_m1 <= wr_data[UPPER_LSB +: LINE_W];
        end
        ADDR_W'(3): begin
          shadow.vs_start <= wr_data[LINE_W-1:0];
          shadow.vs_wid   <= wr_data[UPPER_LSB +: VSW_W];
          shadow.vs_low   <= wr_data[DATA_W-1];
        end
        ADDR_W'(COMMIT_ADDR): shadow.dbl <= wr_data[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= '0;
      armed   <= 1'b0;
      pending <= 1'b1;
    end else begin
      if (apply) active <= shadow;
      if (commit_wr)  armed <= 1'b1;
      else if (apply) armed <= 1'b0;
      // a fresh geometry write outranks the release
      if (timing_wr)  pending <= 1'b1;
      else if (apply) pending <= 1'b0;
    end
  end

  logic unused_bits;
  assign unused_bits = ^wr_data;

  assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> $past(apply));
  assert_coincident_R12: assert property (@(posedge clk) disable iff (!rst_n)
    timing_wr |=> pending);
endmodule

// File: rtl/crtc_scan_counters.sv
module crtc_scan_counters
  import crtc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HCHAR_W-1:0] htot_m1,
  input  logic [LINE_W-1:0]  vtot_m1,
  input  logic               dbl,
  output logic [PIX_W-1:0]   hcnt,
  output logic [LINE_W-1:0]  vcnt,
  output logic               frame_wrap
);
  logic [PIX_W:0] h_last;
  logic line_end;
  logic v_last;
  logic rep;

  assign h_last     = chars_to_pix(htot_m1) - (PIX_W+1)'(1);
  assign line_end   = ({1'b0, hcnt} == h_last);
  assign v_last     = (vcnt == vtot_m1);
  assign frame_wrap = line_end && v_last && (!dbl || rep);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
      rep  <= 1'b0;
    end else if (line_end) begin
      hcnt <= '0;
      if (frame_wrap) begin
        vcnt <= '0;
        rep  <= 1'b0;
      end else if (dbl && !rep) begin
        rep  <= 1'b1;
      end else begin
        rep  <= 1'b0;
        vcnt <= vcnt + LINE_W'(1);
      end
    end else begin
      hcnt <= hcnt + PIX_W'(1);
    end
  end

  assert_hwrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (hcnt == '0));
  assert_dblhold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && dbl && !rep) |=> (vcnt == $past(vcnt)));
endmodule

// File: rtl/crtc_out_gate.sv
module crtc_out_gate
  import crtc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PIX_W-1:0]   hcnt,
  input  logic [LINE_W-1:0]  vcnt,
  input  logic [HCHAR_W-1:0] hdisp_m1,
  input  logic [PIX_W-1:0]   hs_start,
  input  logic [HSW_W-1:0]   hs_wid,
  input  logic               hs_low,
  input  logic [LINE_W-1:0]  vdisp_m1,
  input  logic [LINE_W-1:0]  vs_start,
  input  logic [VSW_W-1:0]   vs_wid,
  input  logic               vs_low,
  input  logic [1:0]         pm,
  input  logic               quiet,
  output logic               hsync,
  output logic               vsync,
  output logic               disp_en,
  output logic               fetch_req
);
  pm_mode_t mode;
  logic region;
  logic hs_raw, vs_raw;
  logic hs_ok, vs_ok, de_ok, fetch_ok;

  assign mode   = pm_mode_t'(pm);
  assign region = ({1'b0, hcnt} < chars_to_pix(hdisp_m1)) && (vcnt <= vdisp_m1);
  assign hs_raw = in_span(SPAN_W'(hcnt), SPAN_W'(hs_start),
                          SPAN_W'(eff_hsw(hs_wid)) << CHAR_SHIFT);
  assign vs_raw = in_span(SPAN_W'(vcnt), SPAN_W'(vs_start),
                          SPAN_W'(eff_vsw(vs_wid)));

  always_comb begin
    hs_ok = 1'b0; vs_ok = 1'b0; de_ok = 1'b0; fetch_ok = 1'b0;
    case (mode)
      PM_ON:      begin hs_ok = 1'b1; vs_ok = 1'b1; de_ok = 1'b1; fetch_ok = 1'b1; end
      PM_STANDBY: begin vs_ok = 1'b1; fetch_ok = 1'b1; end
      PM_SUSPEND: begin hs_ok = 1'b1; fetch_ok = 1'b1; end
      default: ;
    endcase
  end

  assign hsync     = (hs_raw && hs_ok && !quiet) ^ hs_low;
  assign vsync     = (vs_raw && vs_ok && !quiet) ^ vs_low;
  assign disp_en   = region && de_ok && !quiet;
  assign fetch_req = region && fetch_ok && !quiet;

  assert_offfetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_OFF) |-> (!fetch_req && !disp_en && hsync == hs_low && vsync == vs_low));
  assert_standby_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_STANDBY) |-> (hsync == hs_low && !disp_en));
  assert_suspend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_SUSPEND) |-> (vsync == vs_low && !disp_en));
endmodule

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen
  import crtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        pm_mode,
  output logic              hsync,
  output logic              vsync,
  output logic              disp_en,
  output logic              fetch_req,
  output logic [PIX_W-1:0]  pix_x,
  output logic [LINE_W-1:0] line_y
);
  crtc_cfg_t cfg;
  logic quiet;
  logic frame_wrap;

  crtc_shadow_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .frame_wrap(frame_wrap), .active(cfg), .quiet(quiet)
  );

  crtc_scan_counters u_cnt (
    .clk(clk), .rst_n(rst_n), .htot_m1(cfg.htot_m1), .vtot_m1(cfg.vtot_m1),
    .dbl(cfg.dbl), .hcnt(pix_x), .vcnt(line_y), .frame_wrap(frame_wrap)
  );

  crtc_out_gate u_gate (
    .clk(clk), .rst_n(rst_n), .hcnt(pix_x), .vcnt(line_y),
    .hdisp_m1(cfg.hdisp_m1), .hs_start(cfg.hs_start), .hs_wid(cfg.hs_wid),
    .hs_low(cfg.hs_low), .vdisp_m1(cfg.vdisp_m1), .vs_start(cfg.vs_start),
    .vs_wid(cfg.vs_wid), .vs_low(cfg.vs_low), .pm(pm_mode), .quiet(quiet),
    .hsync(hsync), .vsync(vsync), .disp_en(disp_en), .fetch_req(fetch_req)
  );
endmodule

// File: tb/crtc_timing_gen_test.sv
`timescale 1ns/1ps
module crtc_timing_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0] pm_mode = 2'd0;
  logic hsync, vsync, disp_en, fetch_req;
  logic [10:0] pix_x, line_y;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  crtc_timing_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pm_mode(pm_mode), .hsync(hsync), .vsync(vsync), .disp_en(disp_en),
    .fetch_req(fetch_req), .pix_x(pix_x), .line_y(line_y)
  );

  typedef struct packed {
    int ht; int hd; int hss; int hsw; int vt; int vd; int vss; int vsw;
    int dbl; int hlow; int vlow; int mode;
  } row_t;

  localparam int NROWS = 7;
  localparam row_t ROWS [NROWS] = '{
    '{9, 7, 66, 1, 5, 3, 4, 1, 0, 0, 0, 0},
    '{9, 7, 66, 2, 5, 3, 4, 2, 0, 1, 0, 1},
    '{9, 7, 64, 3, 5, 3, 4, 1, 1, 0, 1, 2},
    '{9, 7, 66, 1, 5, 3, 4, 1, 0, 0, 0, 3},
    '{7, 5, 3, 2, 4, 3, 1, 3, 1, 0, 0, 0},
    '{69, 59, 485, 63, 3, 2, 3, 0, 0, 0, 0, 0},
    '{3, 1, 17, 0, 39, 29, 32, 31, 0, 1, 1, 0}
  };

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 32'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic write_geometry(input row_t c);
    wr(0, c.ht | (c.hd << 16));
    wr(1, c.hss | (c.hsw << 16) | (c.hlow << 31));
    wr(2, c.vt | (c.vd << 16));
    wr(3, c.vss | (c.vsw << 16) | (c.vlow << 31));
  endtask

  // after the commit: outputs quiet until the first frame start (R11)
  task automatic sync_frame(input int old_dbl);
    int px, py;
    px = pix_x; py = line_y;
    forever begin
      @(negedge clk);
      if (pix_x == 0 && line_y == 0 && px != 0 && (py != 0 || old_dbl == 0)) break;
      chk("R11", "disp_en before apply", disp_en, 0);
      chk("R11", "fetch_req before apply", fetch_req, 0);
      px = pix_x; py = line_y;
    end
  endtask

  task automatic run_frame(input row_t c);
    int hp, fr, mx, my, rep, w, region, hs_on, vs_on, hs_ok, vs_ok;
    string tde, ths, tvs, tfe;
    hp = (c.ht + 1) * 8;
    fr = hp * (c.vt + 1) * (c.dbl != 0 ? 2 : 1);
    mx = 0; my = 0; rep = 0;
    tde = (c.mode == 0) ? "R1" : (c.mode == 1) ? "R6" : (c.mode == 2) ? "R7" : "R8";
    ths = (c.mode == 1) ? "R6" : (c.mode == 3) ? "R8" : (c.hlow != 0) ? "R5" : "R3";
    tvs = (c.mode == 2) ? "R7" : (c.mode == 3) ? "R8" : (c.vlow != 0) ? "R5" : "R4";
    tfe = (c.mode == 3) ? "R8" : "R9";
    hs_ok = (c.mode == 0 || c.mode == 2) ? 1 : 0;
    vs_ok = (c.mode == 0 || c.mode == 1) ? 1 : 0;
    for (int i = 0; i < fr; i++) begin
      region = (mx < (c.hd + 1) * 8 && my <= c.vd) ? 1 : 0;
      w = (c.hsw == 0 ? 1 : c.hsw) * 8;
      hs_on = (mx >= c.hss && mx < c.hss + w) ? 1 : 0;
      w = (c.vsw == 0 ? 1 : c.vsw);
      vs_on = (my >= c.vss && my < c.vss + w) ? 1 : 0;
      chk("R1", "pix_x", pix_x, mx);
      chk(c.dbl != 0 ? "R10" : "R2", "line_y", line_y, my);
      chk(tde, "disp_en", disp_en, (c.mode == 0) ? region : 0);
      chk(tfe, "fetch_req", fetch_req, (c.mode != 3) ? region : 0);
      chk(ths, "hsync", hsync, (hs_on & hs_ok) ^ c.hlow);
      chk(tvs, "vsync", vsync, (vs_on & vs_ok) ^ c.vlow);
      if (mx == hp - 1) begin
        mx = 0;
        if (my == c.vt && (c.dbl == 0 || rep == 1)) begin my = 0; rep = 0; end
        else if (c.dbl != 0 && rep == 0) rep = 1;
        else begin rep = 0; my = my + 1; end
      end else begin
        mx = mx + 1;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    int old_dbl;
    // R13: reset state
    @(negedge clk);
    chk("R13", "pix_x in reset", pix_x, 0);
    chk("R13", "line_y in reset", line_y, 0);
    chk("R13", "disp_en in reset", disp_en, 0);
    chk("R13", "fetch_req in reset", fetch_req, 0);
    chk("R13", "hsync in reset", hsync, 0);
    chk("R13", "vsync in reset", vsync, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk("R13", "disp_en unprogrammed", disp_en, 0);
      chk("R13", "fetch_req unprogrammed", fetch_req, 0);
      chk("R13", "hsync unprogrammed", hsync, 0);
      chk("R13", "vsync unprogrammed", vsync, 0);
    end

    // table walk
    old_dbl = 0;
    for (int r = 0; r < NROWS; r++) begin
      pm_mode = 2'(ROWS[r].mode);
      write_geometry(ROWS[r]);
      wr(4, ROWS[r].dbl);
      sync_frame(old_dbl);
      run_frame(ROWS[r]);
      old_dbl = ROWS[r].dbl;
    end

    // R12: geometry write in the cycle of the armed frame wrap (old: last row)
    pm_mode = 2'd0;
    write_geometry(ROWS[0]);
    wr(4, ROWS[0].dbl);
    while (!(pix_x == 11'd31 && line_y == 11'd39)) @(negedge clk);
    wr(0, ROWS[0].ht | (ROWS[0].hd << 16));
    chk("R12", "pix_x after coincident wrap", pix_x, 0);
    chk("R12", "line_y after coincident wrap", line_y, 0);
    for (int k = 0; k < 16; k++) begin
      chk("R12", "disp_en stays quiet", disp_en, 0);
      chk("R12", "fetch_req stays quiet", fetch_req, 0);
      @(negedge clk);
    end
    wr(4, ROWS[0].dbl);
    sync_frame(0);
    run_frame(ROWS[0]);

    finish_run();
  end
endmodule